// File: doc/BRIEF.md
# Operand Specifier Decoder

This block takes one operand specifier for a 16-bit processor from a byte stream and turns it into a decoded record. A specifier is a mode byte followed by one or two extension bytes. The mode byte carries everything needed to parse the rest of the field. Its top two bits pick the class: a constant, a register, an extended register, or a memory operand. Memory operands come in four sub-forms, and both register and memory operands carry a byte-lane order.

Bytes are delivered with a valid/ready handshake. Once the last byte of a specifier has been taken, the decoder stops accepting input and holds the finished record with a valid flag until the consumer acknowledges it. It then goes back to waiting for the next mode byte. The record gives the operand kind, the constant, the register number, the segment, the memory displacement or absolute address, the port number, the lane order, the invert flag and the total number of bytes consumed. Fields that do not apply to the decoded kind are driven to zero.

Executing the access, reading the register file and forming addresses are left to the blocks downstream.

Top module: `opspec_decoder`

## Requirements
- R1: A synchronous active-low reset puts the decoder in the state where it waits for a mode byte: `in_ready`=1 and `out_valid`=0.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays high until the last byte of a specifier has been taken. From that edge on, `out_valid` is 1 and `in_ready` is 0 until an edge with `out_ack` high. After that edge `out_valid` is 0 and `in_ready` is 1.
- R3: While `out_valid` is high and `out_ack` is low, every record field holds its value.
- R4: When mode bits 7:6 are 00, the operand is a constant: `out_kind`=0, `out_inv` = bit 5 and `out_lane`=0. If bit 4 is 0, one byte follows, it is zero-extended into `out_const`, and `out_len`=2. If bit 4 is 1, two bytes follow, low byte first, and `out_len`=3.
- R5: Mode bits 7:6 = 01 give `out_kind`=1 (register) and 10 give `out_kind`=2 (extended register). For both, `out_inv` = bit 5, one following byte is `out_reg`, `out_lane` = bits 1:0, and `out_len`=2.
- R6: Mode bits 7:6 = 11 give a memory operand. `out_seg` = bits 5:4 (00 code, 01 data, 10 extra, 11 stack), `out_lane` = bits 1:0 (00 word, 01 swapped word, 10 high byte, 11 low byte), and `out_inv`=0.
- R7: Memory bits 3:2 select the sub-form, each with its own `out_kind`. 00 is an absolute 8-bit address: kind 4, and the byte goes to `out_disp`. 01 is register-indirect: kind 5, and the byte goes to `out_reg`. 10 is register plus displacement: kind 6, the first byte goes to `out_reg`, the second to `out_disp`, and `out_len`=3. 11 is an I/O port: kind 7, and the byte goes to `out_port`. The forms with one following byte have `out_len`=2.
- R8: Record fields that the decoded kind does not use read zero.
- R9: The don't-care mode bits have no effect on the record. These are bits 3:0 in the constant class and bits 4:2 in the register classes.
- R10: A byte offered while a record is held is not consumed. After the acknowledge, it is taken as the next mode byte.
- R11: A reset in the middle of a specifier discards the bytes already taken. The next byte accepted is treated as a mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Specifier byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record is held |
| out_ack | input | 1 | Consumer takes the record |
| out_kind | output | 3 | Operand kind code |
| out_const | output | 16 | Constant value |
| out_reg | output | 8 | Register number |
| out_seg | output | 2 | Segment select |
| out_disp | output | 8 | Displacement or absolute address |
| out_port | output | 8 | I/O port number |
| out_lane | output | 2 | Byte-lane order |
| out_inv | output | 1 | Invert flag |
| out_len | output | 2 | Bytes consumed (2 or 3) |

## Verification
The block has no top-level parameters. The bench builds it as it is: 8-bit bytes and a 16-bit constant, which are the only widths the mode-byte layout defines. At that size every class, every memory sub-form, every segment and every lane code can be reached with a handful of specifiers, and each of them is driven at least once. The bench delays the acknowledge by a varying number of cycles so that bytes of the next specifier arrive while a record is held. This exercises the hold and no-consume behaviour as well as the plain back-to-back flow.

// File: rtl/opspec_pkg.sv
// Package: shared constants, enums and the decoded-record type for the
// operand specifier decoder. Assumes 8-bit stream bytes and 16-bit words.
package opspec_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int KIND_W  = 3;
    localparam int LEN_W   = 2;
    localparam int SEG_W   = 2;
    localparam int LANE_W  = 2;

    // Bit positions inside the mode byte
    localparam int CLS_HI   = 7;
    localparam int CLS_LO   = 6;
    localparam int INV_BIT  = 5;
    localparam int WIDE_BIT = 4;
    localparam int SEG_HI   = 5;
    localparam int SEG_LO   = 4;
    localparam int FORM_HI  = 3;
    localparam int FORM_LO  = 2;
    localparam int LANE_HI  = 1;
    localparam int LANE_LO  = 0;

    // Byte counts reported on the length output
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(3);

    typedef enum logic [1:0] {
        CLS_CONST = 2'b00,
        CLS_REG   = 2'b01,
        CLS_XREG  = 2'b10,
        CLS_MEM   = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        MF_ABS   = 2'b00,
        MF_IND   = 2'b01,
        MF_RDISP = 2'b10,
        MF_PORT  = 2'b11
    } memform_e;

    typedef enum logic [KIND_W-1:0] {
        K_CONST = 3'd0,
        K_REG   = 3'd1,
        K_XREG  = 3'd2,
        K_MABS  = 3'd4,
        K_MIND  = 3'd5,
        K_MDISP = 3'd6,
        K_PORT  = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        ST_MODE = 2'd0,
        ST_EXT1 = 2'd1,
        ST_EXT2 = 2'd2,
        ST_HOLD = 2'd3
    } st_e;

    typedef struct packed {
        kind_e               kind;
        logic [WORD_W-1:0]   cval;
        logic [BYTE_W-1:0]   regn;
        logic [SEG_W-1:0]    seg;
        logic [BYTE_W-1:0]   disp;
        logic [BYTE_W-1:0]   port;
        logic [LANE_W-1:0]   lane;
        logic                inv;
        logic [LEN_W-1:0]    len;
    } rec_t;

endpackage

// File: rtl/opspec_len_dec.sv
// Module: opspec_len_dec
// Works out from a captured mode byte whether the specifier carries two
// extension bytes instead of one. Purely combinational. Assumes the mode
// byte is stable while the sequencer is collecting extension bytes.
module opspec_len_dec
    import opspec_pkg::*;
(
    input  logic [BYTE_W-1:0] mode,
    output logic              two_ext
);

    cls_e     cls;
    memform_e form;

    // Split the mode byte into its class and memory sub-form fields
    always_comb begin
        cls  = cls_e'(mode[CLS_HI:CLS_LO]);
        form = memform_e'(mode[FORM_HI:FORM_LO]);
    end

    // Only a wide constant and register-plus-displacement need two bytes
    always_comb begin
        unique case (cls)
            CLS_CONST: two_ext = mode[WIDE_BIT];
            CLS_MEM:   two_ext = (form == MF_RDISP);
            default:   two_ext = 1'b0;
        endcase
    end

endmodule

// File: rtl/opspec_seq.sv
// Module: opspec_seq
// Byte collection sequencer. Captures the mode byte and up to two extension
// bytes under a valid/ready handshake, then holds until acknowledged.
// Assumes two_ext is derived from the captured mode byte (mode_q).
module opspec_seq
    import opspec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              out_ack,
    output logic              hold,
    input  logic              two_ext,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] ext1_q,
    output logic [BYTE_W-1:0] ext2_q
);

    st_e  state;
    logic take;

    // A byte moves on every edge where both sides of the handshake agree
    always_comb begin
        in_ready = (state != ST_HOLD);
        hold     = (state == ST_HOLD);
        take     = in_valid && in_ready;
    end

    // State walk and byte capture; reset discards any partial specifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_MODE;
            mode_q <= '0;
            ext1_q <= '0;
            ext2_q <= '0;
        end else begin
            unique case (state)
                ST_MODE: if (take) begin
                    mode_q <= in_byte;
                    ext1_q <= '0;
                    ext2_q <= '0;
                    state  <= ST_EXT1;
                end
                ST_EXT1: if (take) begin
                    ext1_q <= in_byte;
                    state  <= two_ext ? ST_EXT2 : ST_HOLD;
                end
                ST_EXT2: if (take) begin
                    ext2_q <= in_byte;
                    state  <= ST_HOLD;
                end
                ST_HOLD: if (out_ack) begin
                    state <= ST_MODE;
                end
                default: state <= ST_MODE;
            endcase
        end
    end

endmodule

// File: rtl/opspec_record.sv
// Module: opspec_record
// Builds the decoded record from the captured mode and extension bytes.
// Combinational; every field the kind does not use is forced to zero.
// Assumes the inputs are held stable by the sequencer while the record is
// presented.
module opspec_record
    import opspec_pkg::*;
(
    input  logic [BYTE_W-1:0] mode,
    input  logic [BYTE_W-1:0] ext1,
    input  logic [BYTE_W-1:0] ext2,
    output rec_t              rec
);

    cls_e     cls;
    memform_e form;

    // Field split of the mode byte
    always_comb begin
        cls  = cls_e'(mode[CLS_HI:CLS_LO]);
        form = memform_e'(mode[FORM_HI:FORM_LO]);
    end

    // Record assembly per class and memory sub-form
    always_comb begin
        rec      = '0;
        rec.kind = K_CONST;
        rec.len  = LEN_SHORT;
        unique case (cls)
            CLS_CONST: begin
                rec.kind = K_CONST;
                rec.inv  = mode[INV_BIT];
                if (mode[WIDE_BIT]) begin
                    rec.cval = {ext2, ext1};
                    rec.len  = LEN_LONG;
                end else begin
                    rec.cval = {{(WORD_W-BYTE_W){1'b0}}, ext1};
                end
            end
            CLS_REG, CLS_XREG: begin
                rec.kind = (cls == CLS_REG) ? K_REG : K_XREG;
                rec.inv  = mode[INV_BIT];
                rec.regn = ext1;
                rec.lane = mode[LANE_HI:LANE_LO];
            end
            CLS_MEM: begin
                rec.seg  = mode[SEG_HI:SEG_LO];
                rec.lane = mode[LANE_HI:LANE_LO];
                unique case (form)
                    MF_ABS: begin
                        rec.kind = K_MABS;
                        rec.disp = ext1;
                    end
                    MF_IND: begin
                        rec.kind = K_MIND;
                        rec.regn = ext1;
                    end
                    MF_RDISP: begin
                        rec.kind = K_MDISP;
                        rec.regn = ext1;
                        rec.disp = ext2;
                        rec.len  = LEN_LONG;
                    end
                    default: begin
                        rec.kind = K_PORT;
                        rec.port = ext1;
                    end
                endcase
            end
            default: rec = '0;
        endcase
    end

endmodule

// File: rtl/opspec_decoder.sv
// Module: opspec_decoder (top)
// Parses one operand specifier (mode byte plus one or two extension bytes)
// from a handshaked byte stream and holds the decoded record until the
// consumer acknowledges it. Assumes a single clock and synchronous
// active-low reset; does not perform the access itself.
module opspec_decoder
    import opspec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ack,
    output logic [KIND_W-1:0]   out_kind,
    output logic [WORD_W-1:0]   out_const,
    output logic [BYTE_W-1:0]   out_reg,
    output logic [SEG_W-1:0]    out_seg,
    output logic [BYTE_W-1:0]   out_disp,
    output logic [BYTE_W-1:0]   out_port,
    output logic [LANE_W-1:0]   out_lane,
    output logic                out_inv,
    output logic [LEN_W-1:0]    out_len
);

    logic [BYTE_W-1:0] mode_q;
    logic [BYTE_W-1:0] ext1_q;
    logic [BYTE_W-1:0] ext2_q;
    logic              two_ext;
    logic              hold;
    rec_t              rec;

    opspec_len_dec u_len (
        .mode    (mode_q),
        .two_ext (two_ext)
    );

    opspec_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_ready (in_ready),
        .out_ack  (out_ack),
        .hold     (hold),
        .two_ext  (two_ext),
        .mode_q   (mode_q),
        .ext1_q   (ext1_q),
        .ext2_q   (ext2_q)
    );

    opspec_record u_rec (
        .mode (mode_q),
        .ext1 (ext1_q),
        .ext2 (ext2_q),
        .rec  (rec)
    );

    // Drive the record onto the output pins
    always_comb begin
        out_valid = hold;
        out_kind  = rec.kind;
        out_const = rec.cval;
        out_reg   = rec.regn;
        out_seg   = rec.seg;
        out_disp  = rec.disp;
        out_port  = rec.port;
        out_lane  = rec.lane;
        out_inv   = rec.inv;
        out_len   = rec.len;
    end

endmodule

// File: rtl/opspec_decoder_chk.sv
// Module: opspec_decoder_chk
// Protocol and record checks on the decoder's ports, bound to the top.
module opspec_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ack,
    input logic [2:0]  out_kind,
    input logic [15:0] out_const,
    input logic [7:0]  out_reg,
    input logic [7:0]  out_disp,
    input logic [7:0]  out_port,
    input logic [1:0]  out_lane,
    input logic        out_inv,
    input logic [1:0]  out_len
);

    AST_NO_READY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ack |=> !out_valid && in_ready); // R2

    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_kind) && $stable(out_const)
            && $stable(out_reg) && $stable(out_disp) && $stable(out_port)
            && $stable(out_lane) && $stable(out_inv) && $stable(out_len)); // R3

    AST_SHORT_CONST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd0 && out_len == 2'd2 |-> out_const[15:8] == 8'h00); // R4

    AST_MEM_NO_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind[2] |-> !out_inv); // R6

    AST_LONG_ONLY_TWO_BYTE_FORMS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len == 2'd3 |-> out_kind == 3'd0 || out_kind == 3'd6); // R7

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind != 3'd7 |-> out_port == 8'h00); // R8

endmodule

bind opspec_decoder opspec_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .out_kind  (out_kind),
    .out_const (out_const),
    .out_reg   (out_reg),
    .out_disp  (out_disp),
    .out_port  (out_port),
    .out_lane  (out_lane),
    .out_inv   (out_inv),
    .out_len   (out_len)
);

// File: tb/tb_opspec_decoder.sv
`timescale 1ns/1ps
module tb_opspec_decoder;

    typedef struct {
        logic [2:0]  kind;
        logic [15:0] cval;
        logic [7:0]  regn;
        logic [1:0]  seg;
        logic [7:0]  disp;
        logic [7:0]  port;
        logic [1:0]  lane;
        logic        inv;
        logic [1:0]  len;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ack = 1'b0;
    logic [2:0]  out_kind;
    logic [15:0] out_const;
    logic [7:0]  out_reg;
    logic [1:0]  out_seg;
    logic [7:0]  out_disp;
    logic [7:0]  out_port;
    logic [1:0]  out_lane;
    logic        out_inv;
    logic [1:0]  out_len;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   ack_delay = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    opspec_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ack(out_ack),
        .out_kind(out_kind), .out_const(out_const), .out_reg(out_reg),
        .out_seg(out_seg), .out_disp(out_disp), .out_port(out_port),
        .out_lane(out_lane), .out_inv(out_inv), .out_len(out_len)
    );

    // Plain boolean check with a tagged failure line
    task automatic check(input bit ok, input string what, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", what, act, exp);
        end
    endtask

    // Compare all record fields against one expected item
    task automatic cmp_rec(input exp_t e, input string phase);
        bit ok;
        ok = out_kind == e.kind && out_const == e.cval && out_reg == e.regn &&
             out_seg == e.seg && out_disp == e.disp && out_port == e.port &&
             out_lane == e.lane && out_inv == e.inv && out_len == e.len;
        check(ok, {e.tag, phase},
            $sformatf("k=%0d c=%h r=%h s=%0d d=%h p=%h l=%0d i=%0b n=%0d", out_kind, out_const,
                      out_reg, out_seg, out_disp, out_port, out_lane, out_inv, out_len),
            $sformatf("k=%0d c=%h r=%h s=%0d d=%h p=%h l=%0d i=%0b n=%0d", e.kind, e.cval,
                      e.regn, e.seg, e.disp, e.port, e.lane, e.inv, e.len));
    endtask

    // Driver: offer one byte, entered and left at a falling edge
    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Driver: queue the expected record, then send the bytes
    task automatic send(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input exp_t e);
        sb.push_back(e);
        put_byte(b0);
        put_byte(b1);
        if (nb == 3) put_byte(b2);
    endtask

    function automatic exp_t mk(input logic [2:0] k, input logic [15:0] c, input logic [7:0] r,
                                input logic [1:0] s, input logic [7:0] d, input logic [7:0] p,
                                input logic [1:0] l, input logic i, input logic [1:0] n,
                                input string tag);
        exp_t e;
        e.kind = k; e.cval = c; e.regn = r; e.seg = s; e.disp = d; e.port = p;
        e.lane = l; e.inv = i; e.len = n; e.tag = tag;
        return e;
    endfunction

    // Monitor: pop and compare each held record, optionally delay the ack
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected record", $sformatf("kind=%0d", out_kind), "none");
                    out_ack = 1'b1;
                    @(negedge clk);
                    out_ack = 1'b0;
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    cmp_rec(e, "");
                    check(!in_ready, "R2 ready low while held", $sformatf("%0b", in_ready), "0");
                    for (int w = 0; w < ack_delay; w++) begin
                        @(negedge clk);
                        cmp_rec(e, " R3 hold");
                    end
                    out_ack = 1'b1;
                    @(negedge clk);
                    out_ack = 1'b0;
                    check(!out_valid && in_ready, "R2 release after ack",
                          $sformatf("v=%0b r=%0b", out_valid, in_ready), "v=0 r=1");
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", "timeout", "finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R1 reset state",
              $sformatf("r=%0b v=%0b", in_ready, out_valid), "r=1 v=0");

        // R4 short constant, R8 unused zero
        send(2, 8'h00, 8'h5A, 8'h00, mk(3'd0, 16'h005A, 8'h00, 2'd0, 8'h00, 8'h00, 2'd0, 1'b0, 2'd2, "R4 R8 short const"));
        // R4 wide constant low first, inverted; R9 bits 3:0 = F ignored
        send(3, 8'h3F, 8'h34, 8'h12, mk(3'd0, 16'h1234, 8'h00, 2'd0, 8'h00, 8'h00, 2'd0, 1'b1, 2'd3, "R4 R9 wide const"));
        send(2, 8'h20, 8'hFF, 8'h00, mk(3'd0, 16'h00FF, 8'h00, 2'd0, 8'h00, 8'h00, 2'd0, 1'b1, 2'd2, "R4 inv const"));
        // R5 register classes
        send(2, 8'h41, 8'h07, 8'h00, mk(3'd1, 16'h0000, 8'h07, 2'd0, 8'h00, 8'h00, 2'd1, 1'b0, 2'd2, "R5 reg"));
        send(2, 8'hBE, 8'hC3, 8'h00, mk(3'd2, 16'h0000, 8'hC3, 2'd0, 8'h00, 8'h00, 2'd2, 1'b1, 2'd2, "R5 R9 xreg"));
        send(2, 8'h43, 8'h80, 8'h00, mk(3'd1, 16'h0000, 8'h80, 2'd0, 8'h00, 8'h00, 2'd3, 1'b0, 2'd2, "R5 reg lane3"));
        send(2, 8'h5F, 8'h80, 8'h00, mk(3'd1, 16'h0000, 8'h80, 2'd0, 8'h00, 8'h00, 2'd3, 1'b0, 2'd2, "R9 reg dontcare"));
        // R6 R7 memory forms, all segments and lanes
        send(2, 8'hC0, 8'h44, 8'h00, mk(3'd4, 16'h0000, 8'h00, 2'd0, 8'h44, 8'h00, 2'd0, 1'b0, 2'd2, "R6 R7 mem abs"));
        send(2, 8'hD5, 8'h10, 8'h00, mk(3'd5, 16'h0000, 8'h10, 2'd1, 8'h00, 8'h00, 2'd1, 1'b0, 2'd2, "R6 R7 mem ind"));
        send(3, 8'hEA, 8'h21, 8'h9C, mk(3'd6, 16'h0000, 8'h21, 2'd2, 8'h9C, 8'h00, 2'd2, 1'b0, 2'd3, "R6 R7 mem disp"));
        send(2, 8'hFF, 8'h7E, 8'h00, mk(3'd7, 16'h0000, 8'h00, 2'd3, 8'h00, 8'h7E, 2'd3, 1'b0, 2'd2, "R6 R7 R8 port"));

        // R10 and R3: next bytes offered while the previous record is held
        ack_delay = 4;
        send(2, 8'h01, 8'hA5, 8'h00, mk(3'd0, 16'h00A5, 8'h00, 2'd0, 8'h00, 8'h00, 2'd0, 1'b0, 2'd2, "R10 first"));
        send(3, 8'hF8, 8'h0B, 8'h66, mk(3'd6, 16'h0000, 8'h0B, 2'd3, 8'h66, 8'h00, 2'd0, 1'b0, 2'd3, "R10 second"));
        send(2, 8'h92, 8'h33, 8'h00, mk(3'd2, 16'h0000, 8'h33, 2'd0, 8'h00, 8'h00, 2'd2, 1'b0, 2'd2, "R10 third"));
        while (sb.size() != 0 || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        ack_delay = 0;

        // R11: abandon a partial register-plus-displacement specifier
        put_byte(8'hE8);
        put_byte(8'h55);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R11 R1 after mid reset",
              $sformatf("r=%0b v=%0b", in_ready, out_valid), "r=1 v=0");
        send(2, 8'h00, 8'h11, 8'h00, mk(3'd0, 16'h0011, 8'h00, 2'd0, 8'h00, 8'h00, 2'd0, 1'b0, 2'd2, "R11 fresh spec"));

        while (sb.size() != 0 || out_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule